// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits next to a small processor core and decides when, and for which source, the core is taken into an interrupt routine. Eight sources each raise a sticky pending flag. A flag only turns into a service request when its source is locally enabled, the global enable is on, and its programmed level beats the level currently being serviced. One designated source, the power-fail warning, does not need the global enable.

When a request wins, the controller holds the core for one cycle so the running instruction can finish. It waits one cycle more if that instruction reports an exception window. It then drives a fixed four-step takeover: it cancels the next fetch, pushes the return address, raises the active-level status, and loads the instruction pointer with the source's vector. A return strobe from the core forces the active-level status back to idle and asks for the stack pop.

Software clears flags itself, so a routine that does not clear its own flag is entered again once its level is released.

Top module: `prio_vec_intc`

## Requirements
- R1: After a synchronous reset the active level `ips` is 2'b11, all flags, local enables and the global enable are 0, every priority field is 2'b00, and `irq_req`, `fetch_cancel`, `push_en`, `ip_load` and `pop_en` are low.
- R2: A high `src_evt[n]` sets `flags[n]` at the next edge whatever the enables are. The flag stays set until a high `flag_clr[n]` clears it. When set and clear arrive in the same cycle, the set wins.
- R3: Source n is eligible only when its flag is set, `ien` bit n is 1, its level value is numerically below `ips`, and the global enable is 1. Source 7 is exempt from the global enable. A level field of 2'b11 is never eligible.
- R4: Levels are 2-bit fields held in two registers. `pri_we[r]` loads `pri_d` into register r, which holds sources 4r to 4r+3. The field of the k-th source in that register is at bits [2k+1:2k]. 2'b00 is the most urgent level, then 2'b01, then 2'b10.
- R5: Among eligible sources, the lowest level value wins. Between equal levels, the lower source number wins.
- R6: The vector loaded for source n is 16'h0020 + 2·n.
- R7: If the winning event pulses in cycle c with the controller idle, `irq_req` rises in cycle c+2. `fetch_cancel` is high in cycle c+3. `push_en` is high in cycle c+4, with `push_addr` equal to the `cur_pc` value present in cycle c+2. `ip_load` is high in cycle c+5 with the vector.
- R8: If `excp_win` is high during the stall cycle (c+2), each step of R7 from `fetch_cancel` on moves one cycle later, and `cur_pc` is taken from cycle c+3.
- R9: `ips` equals the serviced level from the `ip_load` cycle on. A source whose level equals or trails `ips` is held off. A strictly more urgent one preempts.
- R10: A high `reti` in a cycle with no service in progress sets `ips` to 2'b11 and drives `pop_en` high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | 8 | Per-source event pulses |
| flag_clr | input | 8 | Per-source flag clear strobes |
| gie_we | input | 1 | Global enable write strobe |
| gie_d | input | 1 | Global enable write value |
| ien_we | input | 1 | Local enable register write strobe |
| ien_d | input | 8 | Local enable write value, one bit per source |
| pri_we | input | 2 | Level register write strobes, one per register |
| pri_d | input | 8 | Level register write value |
| cur_pc | input | 16 | Address the core would fetch next |
| excp_win | input | 1 | Current instruction forbids takeover this cycle |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Takeover in progress, core must stall |
| fetch_cancel | output | 1 | Drop the next instruction fetch |
| push_en | output | 1 | Push `push_addr` on the stack |
| push_addr | output | 16 | Return address to push |
| ip_load | output | 1 | Load the instruction pointer with `ip_vec` |
| ip_vec | output | 16 | Vector of the serviced source |
| pop_en | output | 1 | Pop the return address |
| ips | output | 2 | Active level status, 2'b11 when idle |
| flags | output | 8 | Pending flags |

## Verification
The bench attacks equal-level ties and a low-index-but-less-urgent source against a high-index urgent one. A wrong arbiter would vector to the wrong address or load the wrong level. Nesting is exercised with an equal-level arrival, which must be held off, and a more urgent arrival, which must preempt. An off-by-one compare would either refuse the preemption or re-enter at the same level. The return strobe must reopen a pending equal-level source: if `ips` were not forced to idle, that source would never be serviced. A held exception window must cost exactly one extra cycle. The power-fail source must be served with the global enable off, while another source must not be.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LVL_W = 2;
  localparam logic [LVL_W-1:0] LVL_IDLE = 2'b11;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_STALL,
    SEQ_SLIP,
    SEQ_CANCEL,
    SEQ_PUSH,
    SEQ_LOAD
  } seq_state_t;
endpackage

// File: rtl/intc_src_regs.sv
module intc_src_regs #(
  parameter int NSRC     = 8,
  parameter int PRI_REGS = 2,
  localparam int LVL_W   = intc_pkg::LVL_W,
  localparam int SPR     = NSRC / PRI_REGS,
  localparam int PW      = LVL_W * SPR
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NSRC-1:0]             src_evt,
  input  logic [NSRC-1:0]             flag_clr,
  input  logic                        gie_we,
  input  logic                        gie_d,
  input  logic                        ien_we,
  input  logic [NSRC-1:0]             ien_d,
  input  logic [PRI_REGS-1:0]         pri_we,
  input  logic [PW-1:0]               pri_d,
  output logic [NSRC-1:0]             flags_q,
  output logic [NSRC-1:0]             ien_q,
  output logic                        gie_q,
  output logic [NSRC-1:0][LVL_W-1:0]  pri_q
);

  // Sticky flags: a new event outranks a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~flag_clr) | src_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q <= 1'b0;
      ien_q <= '0;
    end else begin
      if (gie_we) gie_q <= gie_d;
      if (ien_we) ien_q <= ien_d;
    end
  end

  // Level fields: register r carries sources r*SPR .. r*SPR+SPR-1.
  always_ff @(posedge clk) begin
    if (rst) begin
      pri_q <= '0;
    end else begin
      for (int r = 0; r < PRI_REGS; r++) begin
        if (pri_we[r]) begin
          for (int k = 0; k < SPR; k++) begin
            pri_q[r*SPR+k] <= pri_d[LVL_W*k +: LVL_W];
          end
        end
      end
    end
  end

  assert_flag_set_R2: assert property (@(posedge clk) disable iff (rst)
    (|src_evt) |=> ((flags_q & $past(src_evt)) == $past(src_evt)));

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NSRC   = 8,
  parameter int PF_SRC = 7,
  localparam int LVL_W = intc_pkg::LVL_W,
  localparam int ID_W  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]             flags,
  input  logic [NSRC-1:0]             ien,
  input  logic                        gie,
  input  logic [NSRC-1:0][LVL_W-1:0]  pri,
  input  logic [LVL_W-1:0]            ips,
  output logic                        win_valid,
  output logic [ID_W-1:0]             win_id,
  output logic [LVL_W-1:0]            win_lvl
);

  logic [NSRC-1:0] elig;

  for (genvar g = 0; g < NSRC; g++) begin : g_elig
    localparam bit BYPASS = (g == PF_SRC);
    assign elig[g] = flags[g] & ien[g] & (gie | BYPASS) & (pri[g] < ips);
  end

  // Ascending scan with strict compare: equal levels keep the lower index.
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_lvl   = intc_pkg::LVL_IDLE;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!win_valid || pri[i] < win_lvl)) begin
        win_valid = 1'b1;
        win_id    = ID_W'(i);
        win_lvl   = pri[i];
      end
    end
  end

endmodule

// File: rtl/intc_sequencer.sv
module intc_sequencer #(
  parameter int NSRC                 = 8,
  parameter int ADDR_W               = 16,
  parameter logic [ADDR_W-1:0] VBASE = 16'h0020,
  parameter int VSTEP                = 2,
  localparam int LVL_W               = intc_pkg::LVL_W,
  localparam int ID_W                = $clog2(NSRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               win_valid,
  input  logic [ID_W-1:0]    win_id,
  input  logic [LVL_W-1:0]   win_lvl,
  input  logic               excp_win,
  input  logic [ADDR_W-1:0]  cur_pc,
  input  logic               reti,
  output logic               irq_req,
  output logic               fetch_cancel,
  output logic               push_en,
  output logic [ADDR_W-1:0]  push_addr,
  output logic               ip_load,
  output logic [ADDR_W-1:0]  ip_vec,
  output logic               pop_en,
  output logic [LVL_W-1:0]   ips
);
  import intc_pkg::*;

  seq_state_t        state;
  logic [LVL_W-1:0]  lvl_q;
  logic [ADDR_W-1:0] ret_q;
  logic [ADDR_W-1:0] vec_q;
  logic [LVL_W-1:0]  ips_q;
  logic              pop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_IDLE;
      lvl_q <= LVL_IDLE;
      ret_q <= '0;
      vec_q <= '0;
      ips_q <= LVL_IDLE;
      pop_q <= 1'b0;
    end else begin
      pop_q <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (reti) begin
            ips_q <= LVL_IDLE;
            pop_q <= 1'b1;
          end else if (win_valid) begin
            state <= SEQ_STALL;
            lvl_q <= win_lvl;
            vec_q <= VBASE + ADDR_W'(win_id) * ADDR_W'(VSTEP);
          end
        end
        SEQ_STALL: begin
          if (excp_win) begin
            state <= SEQ_SLIP;
          end else begin
            state <= SEQ_CANCEL;
            ret_q <= cur_pc;
          end
        end
        SEQ_SLIP: begin
          state <= SEQ_CANCEL;
          ret_q <= cur_pc;
        end
        SEQ_CANCEL: state <= SEQ_PUSH;
        SEQ_PUSH: begin
          state <= SEQ_LOAD;
          ips_q <= lvl_q;
        end
        SEQ_LOAD: state <= SEQ_IDLE;
        default:  state <= SEQ_IDLE;
      endcase
    end
  end

  assign irq_req      = (state != SEQ_IDLE);
  assign fetch_cancel = (state == SEQ_CANCEL);
  assign push_en      = (state == SEQ_PUSH);
  assign ip_load      = (state == SEQ_LOAD);
  assign push_addr    = ret_q;
  assign ip_vec       = vec_q;
  assign pop_en       = pop_q;
  assign ips          = ips_q;

  assert_reti_restore_R10: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_IDLE && reti) |=> (ips == LVL_IDLE && pop_en));

  assert_cancel_then_push_R7: assert property (@(posedge clk) disable iff (rst)
    fetch_cancel |=> push_en);

  assert_push_then_load_R7: assert property (@(posedge clk) disable iff (rst)
    push_en |=> ip_load);

  assert_slip_delay_R8: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_STALL && excp_win) |=> (!fetch_cancel && irq_req));

  assert_level_rises_R9: assert property (@(posedge clk) disable iff (rst)
    ip_load |-> (ips < $past(ips)));

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int NSRC                 = 8,
  parameter int PRI_REGS             = 2,
  parameter int PF_SRC               = 7,
  parameter int ADDR_W               = 16,
  parameter logic [ADDR_W-1:0] VBASE = 16'h0020,
  parameter int VSTEP                = 2,
  localparam int LVL_W               = intc_pkg::LVL_W,
  localparam int PW                  = LVL_W * (NSRC / PRI_REGS),
  localparam int ID_W                = $clog2(NSRC)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSRC-1:0]      src_evt,
  input  logic [NSRC-1:0]      flag_clr,
  input  logic                 gie_we,
  input  logic                 gie_d,
  input  logic                 ien_we,
  input  logic [NSRC-1:0]      ien_d,
  input  logic [PRI_REGS-1:0]  pri_we,
  input  logic [PW-1:0]        pri_d,
  input  logic [ADDR_W-1:0]    cur_pc,
  input  logic                 excp_win,
  input  logic                 reti,
  output logic                 irq_req,
  output logic                 fetch_cancel,
  output logic                 push_en,
  output logic [ADDR_W-1:0]    push_addr,
  output logic                 ip_load,
  output logic [ADDR_W-1:0]    ip_vec,
  output logic                 pop_en,
  output logic [LVL_W-1:0]     ips,
  output logic [NSRC-1:0]      flags
);

  logic [NSRC-1:0]            ien_q;
  logic                       gie_q;
  logic [NSRC-1:0][LVL_W-1:0] pri_q;
  logic                       win_valid;
  logic [ID_W-1:0]            win_id;
  logic [LVL_W-1:0]           win_lvl;

  intc_src_regs #(.NSRC(NSRC), .PRI_REGS(PRI_REGS)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .src_evt  (src_evt),
    .flag_clr (flag_clr),
    .gie_we   (gie_we),
    .gie_d    (gie_d),
    .ien_we   (ien_we),
    .ien_d    (ien_d),
    .pri_we   (pri_we),
    .pri_d    (pri_d),
    .flags_q  (flags),
    .ien_q    (ien_q),
    .gie_q    (gie_q),
    .pri_q    (pri_q)
  );

  intc_arbiter #(.NSRC(NSRC), .PF_SRC(PF_SRC)) u_arb (
    .flags     (flags),
    .ien       (ien_q),
    .gie       (gie_q),
    .pri       (pri_q),
    .ips       (ips),
    .win_valid (win_valid),
    .win_id    (win_id),
    .win_lvl   (win_lvl)
  );

  intc_sequencer #(
    .NSRC(NSRC), .ADDR_W(ADDR_W), .VBASE(VBASE), .VSTEP(VSTEP)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .win_valid    (win_valid),
    .win_id       (win_id),
    .win_lvl      (win_lvl),
    .excp_win     (excp_win),
    .cur_pc       (cur_pc),
    .reti         (reti),
    .irq_req      (irq_req),
    .fetch_cancel (fetch_cancel),
    .push_en      (push_en),
    .push_addr    (push_addr),
    .ip_load      (ip_load),
    .ip_vec       (ip_vec),
    .pop_en       (pop_en),
    .ips          (ips)
  );

  // With the global mask off, only the bypass source may be offered.
  assert_mask_bypass_R3: assert property (@(posedge clk) disable iff (rst)
    (win_valid && !gie_q) |-> (win_id == ID_W'(PF_SRC)));

  // The offered winner always beats the active level.
  assert_winner_beats_level_R9: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (win_lvl < ips));

endmodule

// File: tb/tb_prio_vec_intc.sv
module tb_prio_vec_intc;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] ret;
    logic [15:0] vec;
    logic [1:0]  lvl;
    logic [31:0] pcyc;
  } svc_item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  src_evt = '0, flag_clr = '0, ien_d = '0, pri_d = '0;
  logic        gie_we = 0, gie_d = 0, ien_we = 0, excp_win = 0, reti = 0;
  logic [1:0]  pri_we = '0;
  logic [15:0] cur_pc = '0;
  logic        irq_req, fetch_cancel, push_en, ip_load, pop_en;
  logic [15:0] push_addr, ip_vec;
  logic [1:0]  ips;
  logic [7:0]  flags;

  int checks = 0, errors = 0, cyc = 0, cancel_cyc = -1;
  bit done = 0;
  svc_item_t sb[$];
  svc_item_t cur;
  logic [15:0] stk[$];
  logic [15:0] pop_exp[$];

  prio_vec_intc dut (
    .clk(clk), .rst(rst), .src_evt(src_evt), .flag_clr(flag_clr),
    .gie_we(gie_we), .gie_d(gie_d), .ien_we(ien_we), .ien_d(ien_d),
    .pri_we(pri_we), .pri_d(pri_d), .cur_pc(cur_pc), .excp_win(excp_win),
    .reti(reti), .irq_req(irq_req), .fetch_cancel(fetch_cancel),
    .push_en(push_en), .push_addr(push_addr), .ip_load(ip_load),
    .ip_vec(ip_vec), .pop_en(pop_en), .ips(ips), .flags(flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard driver side
  task automatic expect_svc(input logic [15:0] ret, input logic [15:0] vec,
                            input logic [1:0] lvl, input int c, input int slip);
    svc_item_t it;
    it.ret = ret; it.vec = vec; it.lvl = lvl; it.pcyc = 32'(c + 4 + slip);
    sb.push_back(it);
  endtask

  task automatic pulse(input logic [7:0] m, output int c);
    c = cyc; src_evt = m;
    @(negedge clk); src_evt = '0;
  endtask

  task automatic clear(input logic [7:0] m);
    flag_clr = m;
    @(negedge clk); flag_clr = '0;
  endtask

  task automatic do_reti(input logic [15:0] pop_v, output int c);
    pop_exp.push_back(pop_v);
    c = cyc; reti = 1'b1;
    @(negedge clk); reti = 1'b0;
    chk(ips == 2'b11, "R10 ips after return", 32'(ips), 32'h3);
  endtask

  task automatic set_gie(input logic v);
    gie_we = 1; gie_d = v; @(negedge clk); gie_we = 0;
  endtask

  task automatic set_ien(input logic [7:0] v);
    ien_we = 1; ien_d = v; @(negedge clk); ien_we = 0;
  endtask

  task automatic set_pri(input logic [7:0] r0, input logic [7:0] r1);
    pri_we = 2'b11; pri_d = r0;
    @(negedge clk); pri_we = 2'b10; pri_d = r1;
    @(negedge clk); pri_we = 2'b00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor side, with stack model
  always @(negedge clk) begin
    if (!rst) begin
      if (fetch_cancel) cancel_cyc = cyc;
      if (push_en) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R9 unexpected service", 32'(push_addr), 32'h0);
        end else begin
          cur = sb.pop_front();
          chk(push_addr == cur.ret, "R7 return address", 32'(push_addr), 32'(cur.ret));
          chk(32'(cyc) == cur.pcyc, "R7/R8 push cycle", 32'(cyc), cur.pcyc);
          chk(cancel_cyc == cyc - 1, "R7 cancel before push", 32'(cancel_cyc), 32'(cyc - 1));
        end
        stk.push_back(push_addr);
      end
      if (ip_load) begin
        chk(ip_vec == cur.vec, "R6 vector", 32'(ip_vec), 32'(cur.vec));
        chk(ips == cur.lvl, "R9 level on load", 32'(ips), 32'(cur.lvl));
        chk(32'(cyc) == cur.pcyc + 1, "R7 load cycle", 32'(cyc), cur.pcyc + 1);
      end
      if (pop_en) begin
        if (stk.size() == 0 || pop_exp.size() == 0) begin
          chk(1'b0, "R10 pop with empty stack", 32'(stk.size()), 32'(pop_exp.size()));
        end else begin
          logic [15:0] top_v, exp_v;
          top_v = stk.pop_back();
          exp_v = pop_exp.pop_front();
          chk(top_v == exp_v, "R10 popped address", 32'(top_v), 32'(exp_v));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(ips == 2'b11, "R1 ips", 32'(ips), 32'h3);
    chk(flags == 8'h00, "R1 flags", 32'(flags), 32'h0);
    chk({irq_req, fetch_cancel, push_en, ip_load, pop_en} == 5'b0, "R1 strobes",
        32'({irq_req, fetch_cancel, push_en, ip_load, pop_en}), 32'h0);

    // R2/R3: flags set regardless of enables, global mask blocks source 2
    set_ien(8'h04);
    pulse(8'h06, c);
    idle(8);
    chk(flags[2:1] == 2'b11, "R2 flags set while masked", 32'(flags), 32'h6);
    chk(irq_req == 1'b0, "R3 global mask holds off", 32'(irq_req), 32'h0);
    clear(8'hFF);
    chk(flags == 8'h00, "R2 flag clear", 32'(flags), 32'h0);

    // R2: set wins over clear
    src_evt = 8'h20; flag_clr = 8'h20;
    @(negedge clk); src_evt = '0; flag_clr = '0;
    chk(flags[5] == 1'b1, "R2 set beats clear", 32'(flags), 32'h20);
    clear(8'hFF);

    // R3/R6: power-fail source served with global mask off
    set_ien(8'h80);
    cur_pc = 16'h1234;
    pulse(8'h80, c);
    expect_svc(16'h1234, 16'h002E, 2'b00, c, 0);
    idle(8);
    chk(ips == 2'b00, "R3 bypass source served", 32'(ips), 32'h0);
    clear(8'h80);
    do_reti(16'h1234, c);

    // R4/R9: nesting
    set_gie(1'b1);
    set_ien(8'h29);
    set_pri(8'h40, 8'h04);
    cur_pc = 16'h2000;
    pulse(8'h08, c);
    expect_svc(16'h2000, 16'h0026, 2'b01, c, 0);
    idle(8);
    chk(ips == 2'b01, "R4 level from field", 32'(ips), 32'h1);
    pulse(8'h20, c);
    idle(8);
    chk(irq_req == 1'b0 && flags[5], "R9 equal level held off", 32'(irq_req), 32'h0);
    cur_pc = 16'h2100;
    pulse(8'h01, c);
    expect_svc(16'h2100, 16'h0020, 2'b00, c, 0);
    idle(8);
    chk(ips == 2'b00, "R9 preempt raises level", 32'(ips), 32'h0);
    clear(8'h29);
    do_reti(16'h2100, c);
    do_reti(16'h2000, c);

    // R5: equal levels, lower index wins; return reopens the other
    set_ien(8'h50);
    set_pri(8'h00, 8'h22);
    cur_pc = 16'h3000;
    pulse(8'h50, c);
    expect_svc(16'h3000, 16'h0028, 2'b10, c, 0);
    idle(8);
    chk(ips == 2'b10 && flags[6], "R5 tie winner level", 32'(ips), 32'h2);
    clear(8'h10);
    cur_pc = 16'h3100;
    do_reti(16'h3000, c);
    expect_svc(16'h3100, 16'h002C, 2'b10, c, 0);
    idle(8);
    clear(8'h40);
    do_reti(16'h3100, c);

    // R5: urgency beats index
    set_ien(8'h06);
    set_pri(8'h08, 8'h00);
    cur_pc = 16'h4000;
    pulse(8'h06, c);
    expect_svc(16'h4000, 16'h0024, 2'b00, c, 0);
    idle(8);
    clear(8'h04);
    cur_pc = 16'h4100;
    do_reti(16'h4000, c);
    expect_svc(16'h4100, 16'h0022, 2'b10, c, 0);
    idle(8);
    clear(8'h02);
    do_reti(16'h4100, c);

    // R8: exception window adds one cycle
    set_ien(8'h01);
    set_pri(8'h00, 8'h00);
    cur_pc = 16'h5000;
    excp_win = 1'b1;
    pulse(8'h01, c);
    expect_svc(16'h5000, 16'h0020, 2'b00, c, 1);
    idle(10);
    excp_win = 1'b0;
    clear(8'h01);
    do_reti(16'h5000, c);

    // R3/R4: level 2'b11 never served; local enable off never served
    set_ien(8'h08);
    set_pri(8'hC0, 8'h00);
    pulse(8'h08, c);
    idle(8);
    chk(irq_req == 1'b0 && flags[3], "R3 level 11 never served", 32'(irq_req), 32'h0);
    set_ien(8'h00);
    pulse(8'h04, c);
    idle(8);
    chk(irq_req == 1'b0 && flags[2], "R3 local enable off", 32'(irq_req), 32'h0);
    clear(8'hFF);

    chk(sb.size() == 0, "R7 all services seen", 32'(sb.size()), 32'h0);
    chk(stk.size() == 0, "R10 stack balanced", 32'(stk.size()), 32'h0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule